// File: doc/BRIEF.md
# Serial Flash Write-Side Command Sequencer

This block drives a serial NOR flash over a four-wire SPI link as a mode-0 master and runs the three commands that change the flash contents: whole-chip erase, sector erase and page program. A client hands over one command code and a 24-bit address with a valid/ready handshake. For a page program it then streams the data bytes with their own valid/ready handshake, and marks the final byte with a last flag.

Every operation uses several chip-select frames. The first frame is a one-byte write-enable command. The second frame carries the operation itself. After that the block keeps issuing read-status frames, and it stops when the flash reports that its internal write has finished. Chip select is active low. Between two frames it stays high for at least a programmable number of clocks. The status wait has no timeout, because a whole-chip erase can take tens of seconds. The block raises `busy` from the moment it accepts a command until the final status read comes back idle. In the cycle where `busy` falls, it pulses `done` for one clock.

Top module: `flash_wr_seq`

## Requirements
- R1: After a synchronous active-low reset, `spi_cs_n` is 1, `spi_sclk` is 0, `busy` and `done` are 0, and `req_ready` is 1.
- R2: The link runs in SPI mode 0. `spi_sclk` idles low and stays low whenever `spi_cs_n` is high. Each SCLK high and low phase lasts `CLK_DIV` system clocks. `spi_mosi` changes only while SCLK is low, and bytes are sent most significant bit first. Every frame holds a whole number of bytes.
- R3: Every accepted operation starts with a frame that holds only the byte 0x06 (write enable).
- R4: `req_cmd` values 2'b10 and 2'b11 select a whole-chip erase. Its second frame is the single byte 0xC7, with no address.
- R5: `req_cmd` = 2'b01 selects a sector erase. Its second frame is 0xD8 followed by the three address bytes, `req_addr[23:16]` first and `req_addr[7:0]` last.
- R6: `req_cmd` = 2'b00 selects a page program. Its second frame is 0x02, then the three address bytes (high byte first), then each data byte in the order it was accepted. A data byte is accepted on a cycle where `wr_valid` and `wr_ready` are both 1. The frame ends after the byte that carried `wr_last` = 1. `wr_ready` is high only while the block is waiting for a data byte inside that frame.
- R7: The address of a page program is sent exactly once. Data bytes beyond a 256-byte page boundary go out in the same frame. No new address is sent and no carry reaches the page address, so the flash wraps within the page.
- R8: Between the end of one frame and the start of the next, `spi_cs_n` is high for at least `MIN_GAP` system clocks.
- R9: After the operation frame, the block sends frames of 0x05 followed by 0x00 (a status read). It repeats them for as long as bit 0 of the byte read back in the second position is 1, with no upper limit on the number of polls.
- R10: `busy` rises in the cycle after a request is accepted (`req_valid` and `req_ready` both 1). It stays high until the first status read whose bit 0 is 0. `req_ready` is 0 while `busy` is high, so requests raised during an operation have no effect. `done` pulses for exactly one cycle, in the cycle where `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Block is idle and can take a command |
| req_cmd | input | 2 | 00 page program, 01 sector erase, 1x whole-chip erase |
| req_addr | input | 24 | Flash byte address for program or sector erase |
| wr_valid | input | 1 | Program data byte valid |
| wr_ready | output | 1 | Block takes a program data byte |
| wr_data | input | 8 | Program data byte |
| wr_last | input | 1 | Marks the final program data byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | SPI serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench stands in for the flash. It decodes each chip-select frame bit by bit and returns a chosen number of busy status reads. The three commands are each run with a different address. This shows that the right opcode is chosen and that the address bytes go out in the right order. The status wait is tried with zero, one, three and forty busy reads, which separates a loop that stops too early from one that polls once too often. Page programs are run in three ways: a short burst sent back-to-back, a single byte that arrives late behind idle cycles, and a 260-byte run that crosses a page boundary. Together they test the data handshake, the last flag, and the absence of any re-addressing. A request held high for a whole operation shows that requests are blocked while `busy` is high.

// File: rtl/flash_wr_pkg.sv
// Shared opcodes and state encodings for the serial flash write sequencer.
package flash_wr_pkg;
    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] OPC_BULK  = 8'hC7;
    localparam logic [7:0] OPC_SECT  = 8'hD8;
    localparam logic [7:0] OPC_PROG  = 8'h02;

    localparam logic [1:0] CMD_PROG  = 2'b00;
    localparam logic [1:0] CMD_SECT  = 2'b01;

    typedef enum logic [1:0] {
        FR_WREN,
        FR_MAIN,
        FR_POLL
    } frame_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_XFER,
        ST_GAP
    } seq_state_e;
endpackage

// File: rtl/flash_spi_shifter.sv
// One-byte SPI mode-0 shifter.
// Shifts tx_byte out MSB first and captures MISO on each rising SCLK.
// Pulses done for one cycle after the eighth falling edge.
// Assumes start is only raised while the shifter is idle; CLK_DIV >= 1.
module flash_spi_shifter #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DW-1:0] DIV_END = DW'(CLK_DIV - 1);

    logic          active;
    logic          phase;
    logic [2:0]    bit_cnt;
    logic [DW-1:0] div_cnt;
    logic [7:0]    sh_q;

    // Divider, half-period phase and bit shifting for one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            phase   <= 1'b0;
            bit_cnt <= '0;
            div_cnt <= '0;
            sh_q    <= '0;
            rx_byte <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                active  <= 1'b1;
                phase   <= 1'b0;
                bit_cnt <= '0;
                div_cnt <= '0;
                sh_q    <= tx_byte;
            end else if (active) begin
                if (div_cnt == DIV_END) begin
                    div_cnt <= '0;
                    if (!phase) begin
                        phase   <= 1'b1;
                        rx_byte <= {rx_byte[6:0], miso};
                    end else begin
                        phase   <= 1'b0;
                        sh_q    <= {sh_q[6:0], 1'b0};
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end
                    end
                end else begin
                    div_cnt <= div_cnt + DW'(1);
                end
            end
        end
    end

    // Mode 0: clock low except in the second half of each bit.
    assign sclk = active & phase;
    assign mosi = active & sh_q[7];
endmodule

// File: rtl/flash_cs_gap.sv
// Counts clocks with chip select released, saturating at MIN_GAP.
// gap_ok means the deselect time already meets the minimum.
// Assumes MIN_GAP >= 1; reset treats the bus as having been idle long enough.
module flash_cs_gap #(
    parameter int MIN_GAP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic gap_ok
);
    localparam int GW = $clog2(MIN_GAP + 1);
    localparam logic [GW-1:0] GAP_MAX = GW'(MIN_GAP);

    logic [GW-1:0] cnt_q;

    // Restart while selected, count up while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= GAP_MAX;
        else if (!cs_n)
            cnt_q <= '0;
        else if (cnt_q != GAP_MAX)
            cnt_q <= cnt_q + GW'(1);
    end

    assign gap_ok = (cnt_q == GAP_MAX);
endmodule

// File: rtl/flash_wr_seq.sv
// Serial flash write-side command sequencer (SPI mode-0 master).
// Runs write enable, the operation frame, then status polls until the
// write-in-progress bit reads 0. Page program data arrives over valid/ready
// with a last marker. Assumes at least one data byte per page program.
module flash_wr_seq
    import flash_wr_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int MIN_GAP = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_cmd,
    input  logic [23:0] req_addr,
    input  logic        wr_valid,
    output logic        wr_ready,
    input  logic [7:0]  wr_data,
    input  logic        wr_last,
    output logic        busy,
    output logic        done,
    output logic        spi_cs_n,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam logic [2:0] IDX_DATA = 3'd4;

    seq_state_e  state;
    frame_e      frame;
    logic [1:0]  cmd_q;
    logic [23:0] addr_q;
    logic [2:0]  idx;
    logic        last_q;
    logic        wip_q;

    logic [7:0]  tx_byte;
    logic [7:0]  rx_byte;
    logic        byte_last;
    logic        byte_is_data;
    logic        byte_ok;
    logic        sh_start;
    logic        sh_done;
    logic        gap_ok;

    // Pick the next byte of the current frame and whether it ends the frame.
    always_comb begin
        tx_byte      = 8'h00;
        byte_last    = 1'b0;
        byte_is_data = 1'b0;
        unique case (frame)
            FR_WREN: begin
                tx_byte   = OPC_WREN;
                byte_last = 1'b1;
            end
            FR_POLL: begin
                tx_byte   = (idx == 3'd0) ? OPC_RDSR : 8'h00;
                byte_last = (idx != 3'd0);
            end
            default: begin
                case (idx)
                    3'd0: begin
                        tx_byte   = (cmd_q == CMD_PROG) ? OPC_PROG :
                                    (cmd_q == CMD_SECT) ? OPC_SECT : OPC_BULK;
                        byte_last = cmd_q[1];
                    end
                    3'd1: tx_byte = addr_q[23:16];
                    3'd2: tx_byte = addr_q[15:8];
                    3'd3: begin
                        tx_byte   = addr_q[7:0];
                        byte_last = (cmd_q == CMD_SECT);
                    end
                    default: begin
                        tx_byte      = wr_data;
                        byte_is_data = 1'b1;
                        byte_last    = wr_last;
                    end
                endcase
            end
        endcase
    end

    assign byte_ok  = !byte_is_data || wr_valid;
    assign sh_start = (state == ST_LOAD) && byte_ok;

    // Frame and byte sequencing, status capture and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            frame  <= FR_WREN;
            cmd_q  <= '0;
            addr_q <= '0;
            idx    <= '0;
            last_q <= 1'b0;
            wip_q  <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cmd_q  <= req_cmd;
                        addr_q <= req_addr;
                        frame  <= FR_WREN;
                        idx    <= '0;
                        state  <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (byte_ok) begin
                        last_q <= byte_last;
                        state  <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (sh_done) begin
                        if (last_q) begin
                            if (frame == FR_POLL)
                                wip_q <= rx_byte[0];
                            state <= ST_GAP;
                        end else begin
                            idx   <= (idx == IDX_DATA) ? IDX_DATA : idx + 3'd1;
                            state <= ST_LOAD;
                        end
                    end
                end
                default: begin
                    if (gap_ok) begin
                        idx <= '0;
                        case (frame)
                            FR_WREN: begin
                                frame <= FR_MAIN;
                                state <= ST_LOAD;
                            end
                            FR_MAIN: begin
                                frame <= FR_POLL;
                                state <= ST_LOAD;
                            end
                            default: begin
                                if (wip_q) begin
                                    state <= ST_LOAD;
                                end else begin
                                    state <= ST_IDLE;
                                    done  <= 1'b1;
                                end
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign busy      = (state != ST_IDLE);
    assign wr_ready  = (state == ST_LOAD) && byte_is_data;
    assign spi_cs_n  = !((state == ST_LOAD) || (state == ST_XFER));

    flash_spi_shifter #(.CLK_DIV(CLK_DIV)) shifter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (tx_byte),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .done    (sh_done),
        .rx_byte (rx_byte)
    );

    flash_cs_gap #(.MIN_GAP(MIN_GAP)) gap_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (spi_cs_n),
        .gap_ok (gap_ok)
    );
endmodule

// File: rtl/flash_wr_seq_chk.sv
// Protocol checker for flash_wr_seq, attached through bind.
// Watches the port behaviour only; the deselect time is measured with a local counter.
module flash_wr_seq_chk #(
    parameter int MIN_GAP = 3
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic wr_ready,
    input logic busy,
    input logic done,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi
);
    logic [15:0] hi_cnt;

    // Count clocks with chip select high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_cnt <= 16'hFFFF;
        else if (!spi_cs_n)
            hi_cnt <= '0;
        else if (hi_cnt != 16'hFFFF)
            hi_cnt <= hi_cnt + 16'd1;
    end

    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> $stable(spi_mosi));

    assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (hi_cnt >= 16'(MIN_GAP)));

    assert_wr_ready_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (busy && !spi_cs_n));

    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

    assert_no_ready_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_busy_fall_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind flash_wr_seq flash_wr_seq_chk #(.MIN_GAP(MIN_GAP)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .wr_ready  (wr_ready),
    .busy      (busy),
    .done      (done),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi)
);

// File: tb/flash_wr_seq_tb_top.sv
// Scoreboard bench: the driver queues the expected SPI bytes, the flash model decodes and compares.
module flash_wr_seq_tb_top;
    localparam int CLK_DIV = 2;
    localparam int MIN_GAP = 3;
    localparam int END_MARK = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_cmd = 2'b00;
    logic [23:0] req_addr = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  wr_data = '0;
    logic        wr_last = 1'b0;
    logic        busy;
    logic        done;
    logic        spi_cs_n;
    logic        spi_sclk;
    logic        spi_mosi;
    logic        spi_miso = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_q[$];
    int tag_q[$];
    int busy_left = 0;

    always #5 clk = ~clk;

    flash_wr_seq #(.CLK_DIV(CLK_DIV), .MIN_GAP(MIN_GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_addr(req_addr), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
        .busy(busy), .done(done), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    task automatic check(input bit ok, input int r, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d: actual=%0h expected=%0h", r, act, expv);
        end
    endtask

    task automatic push(input int v, input int r);
        exp_q.push_back(v);
        tag_q.push_back(r);
    endtask

    task automatic pop_cmp(input int got);
        if (exp_q.size() == 0) begin
            check(1'b0, 9, got, -1);
        end else begin
            int v;
            int t;
            v = exp_q.pop_front();
            t = tag_q.pop_front();
            check(v == got, t, got, v);
        end
    endtask

    function automatic logic [7:0] dbyte(input int seed, input int i);
        return 8'((i * 37 + seed) ^ (i >> 3));
    endfunction

    // Flash model / monitor: decode frames, compare bytes, answer status reads.
    int       bitc = 0;
    int       byte_no = 0;
    int       gap_cycles = 1000;
    int       hi_cycles = 0;
    logic [7:0] shreg = '0;
    logic     prev_cs = 1'b1;
    logic     prev_sclk = 1'b0;
    logic     in_poll = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_cs_n) begin
                if (!prev_cs) begin
                    check(bitc == 0, 2, bitc, 0);          // R2 whole bytes per frame
                    pop_cmp(END_MARK);
                    if (in_poll && busy_left > 0) busy_left--;
                    in_poll = 1'b0;
                    spi_miso = 1'b0;
                    gap_cycles = 0;
                end
                check(!spi_sclk, 2, spi_sclk, 0);          // R2 idle clock low
                gap_cycles++;
            end else begin
                if (prev_cs) begin
                    check(gap_cycles >= MIN_GAP, 8, gap_cycles, MIN_GAP); // R8
                    bitc = 0;
                    byte_no = 0;
                end
                if (spi_sclk) hi_cycles++;
                if (spi_sclk && !prev_sclk) begin
                    shreg = {shreg[6:0], spi_mosi};
                    bitc++;
                    if (bitc == 8) begin
                        bitc = 0;
                        pop_cmp(int'(shreg));
                        if (byte_no == 0 && shreg == 8'h05) begin
                            in_poll = 1'b1;
                            spi_miso = (busy_left > 0);
                        end
                        byte_no++;
                    end
                end
                if (!spi_sclk && prev_sclk) begin
                    check(hi_cycles == CLK_DIV, 2, hi_cycles, CLK_DIV); // R2 half period
                    hi_cycles = 0;
                end
            end
            prev_cs = spi_cs_n;
            prev_sclk = spi_sclk;
        end
    end

    // Driver: queue expected frames, issue the request, stream data, await done.
    task automatic run_op(input logic [1:0] cmd, input logic [23:0] addr, input int n_data,
                          input int polls, input int stall, input bit stray, input int data_tag);
        push(8'h06, 3); push(END_MARK, 3);                 // R3
        if (cmd[1]) begin
            push(8'hC7, 4);                                // R4
        end else begin
            push(cmd[0] ? 8'hD8 : 8'h02, cmd[0] ? 5 : 6);  // R5 / R6
            push(addr[23:16], cmd[0] ? 5 : data_tag);
            push(addr[15:8], cmd[0] ? 5 : data_tag);
            push(addr[7:0], cmd[0] ? 5 : data_tag);
            if (!cmd[0])
                for (int i = 0; i < n_data; i++) push(dbyte(addr[7:0], i), data_tag);
        end
        push(END_MARK, cmd[1] ? 4 : 5);
        for (int p = 0; p <= polls; p++) begin
            push(8'h05, 9); push(8'h00, 9); push(END_MARK, 9); // R9
        end
        busy_left = polls;

        @(negedge clk);
        check(req_ready == 1'b1, 10, req_ready, 1);
        req_valid = 1'b1;
        req_cmd = cmd;
        req_addr = addr;
        @(negedge clk);
        req_valid = stray;
        req_cmd = stray ? 2'b10 : cmd;
        check(busy && !req_ready, 10, {busy, req_ready}, 2'b10);  // R10

        if (!cmd[1] && !cmd[0]) begin
            for (int i = 0; i < n_data; i++) begin
                repeat (stall) @(negedge clk);
                wr_data = dbyte(addr[7:0], i);
                wr_valid = 1'b1;
                wr_last = (i == n_data - 1);
                while (!wr_ready) @(negedge clk);
                @(negedge clk);
                wr_valid = 1'b0;
                wr_last = 1'b0;
            end
        end

        while (!done) @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b0, 10, busy, 0);                  // R10 busy falls with done
        check(exp_q.size() == 0, 9, exp_q.size(), 0);      // R9 all polls seen
        @(negedge clk);
        check(done == 1'b0, 10, done, 0);                  // R10 single pulse
        check(req_ready && !busy, 10, {busy, req_ready}, 2'b01);
        repeat (4) @(negedge clk);
        check(spi_cs_n == 1'b1, 10, spi_cs_n, 1);          // R10 stray request ignored
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, 0, 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(spi_cs_n == 1'b1, 1, spi_cs_n, 1);
        check(spi_sclk == 1'b0, 1, spi_sclk, 0);
        check(!busy && !done, 1, {busy, done}, 0);
        check(req_ready == 1'b1, 1, req_ready, 1);

        run_op(2'b10, 24'h000000, 0, 0, 0, 1'b0, 6);      // R4 whole-chip erase
        run_op(2'b11, 24'hFFFFFF, 0, 1, 0, 1'b0, 6);      // R4 alternate code
        run_op(2'b01, 24'h123456, 0, 3, 0, 1'b0, 6);      // R5 sector erase
        run_op(2'b00, 24'h000100, 5, 1, 0, 1'b1, 6);      // R6 burst, R10 stray request
        run_op(2'b00, 24'hA5C3E7, 1, 0, 6, 1'b0, 6);      // R6 late single byte
        run_op(2'b00, 24'h0ABCF0, 260, 2, 0, 1'b0, 7);    // R7 page wrap, no re-address
        run_op(2'b01, 24'h3C0000, 0, 40, 0, 1'b0, 6);     // R9 long poll

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule